// File: doc/BRIEF.md
# Link Voltage Mode and Overload Supervisor

This block watches a digitized feedback measurement that tracks the boost converter's output link voltage. Each time the converter's sampler presents a new value with its valid strobe, the block compares that value against levels derived from a programmable nominal reference. From these comparisons it decides whether the power stage runs in startup mode (full power push) or normal regulation. It also raises an overvoltage gate inhibit with hysteresis, and it tracks how long the link keeps dropping back into startup mode. When that time is too long, it forces a long switching lockout and then retries.

All levels are fixed-point per-mille fractions of the reference: low = floor(ref*LOW_PM/1000), high = floor(ref*HIGH_PM/1000), trip = floor(ref*OVP_PM/1000), release = floor(ref*(OVP_PM-OVP_HYS_PM)/1000). The defaults are 900, 1000, 1050 and 15, which give 90 %, 100 %, 105 % and 103.5 %. Time is counted in ticks of an external millisecond strobe.

The controller has four states. ST_BOOT is the initial startup after reset or restart, and overload time does not accumulate in it. ST_RUN is normal mode. ST_SAG is startup mode re-entered from normal mode, and it counts as an overload event. ST_LOCK is the overload lockout. The transitions are named as follows. Boot-to-run happens on a valid sample at or above high. Run-to-sag happens on a valid sample below low. Sag-to-run happens on a valid sample at or above high. Sag-to-lock happens on a tick that finds the accumulator already at TRIP_MS. Lock-to-boot happens on the LOCK_MS-th tick in lockout.

Top module: `link_supervisor`

## Requirements
- R1: After reset, startup_mode=1, ovp_inhibit=0, olp_inhibit=0 and gate_enable=1.
- R2: In ST_BOOT or ST_SAG, a valid sample with value >= high moves the block to normal mode. startup_mode reads 0 in the cycle after that sample's clock edge. A value of high-1 keeps startup_mode=1.
- R3: In normal mode, a valid sample with value < low returns the block to startup mode (ST_SAG). startup_mode reads 1 in the cycle after the sample. A sample equal to low keeps normal mode.
- R4: A valid sample with value > trip sets ovp_inhibit from the next cycle on. A sample equal to trip does not set it.
- R5: Once set, ovp_inhibit stays 1 for valid samples >= release. It clears on the first valid sample < release, with no reset needed.
- R6: Samples with smp_vld=0 change neither ovp_inhibit nor the mode.
- R7: Each ms_tick spent in ST_SAG adds one to an overload accumulator. The accumulator keeps its value across sag-to-run-to-sag cycles. A tick in ST_SAG that finds the accumulator at TRIP_MS enters lockout, so lockout starts on the (TRIP_MS+1)-th accumulated tick. Ticks in ST_BOOT never accumulate.
- R8: After CLEAR_MS ticks of uninterrupted normal mode, the accumulator is cleared.
- R9: In lockout, olp_inhibit=1 and startup_mode=1, and samples do not change the mode. Lockout ends on its LOCK_MS-th tick, which returns the block to ST_BOOT with olp_inhibit=0 and the accumulator cleared.
- R10: gate_enable=0 whenever ovp_inhibit or olp_inhibit is 1. Overvoltage is evaluated in every state, including lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample valid strobe |
| smp_val | input | W | Link feedback sample |
| ref_val | input | W | Nominal reference |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| startup_mode | output | 1 | 1 = startup mode, 0 = normal |
| ovp_inhibit | output | 1 | Overvoltage gate inhibit |
| olp_inhibit | output | 1 | Overload lockout inhibit |
| gate_enable | output | 1 | Switching permitted |

## Verification
A wrong level or a wrong hysteresis state shows on startup_mode or ovp_inhibit one cycle after the offending sample. The bench therefore sweeps every sample value around the levels for several references and checks right after each sample. A wrong accumulator shows up only as a lockout that arrives a tick too early or too late, or at the wrong moment after a clear. The bench therefore checks olp_inhibit after every individual tick in overload sequences built to expose a missed clear, a missed hold, or counting during boot.

// File: rtl/lvs_pkg.sv
package lvs_pkg;
    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_RUN  = 2'd1,
        ST_SAG  = 2'd2,
        ST_LOCK = 2'd3
    } lvs_state_e;

    localparam int PM_SCALE = 1000;
endpackage

// File: rtl/lvs_levels.sv
module lvs_levels #(
    parameter int W          = 12,
    parameter int LOW_PM     = 900,
    parameter int HIGH_PM    = 1000,
    parameter int OVP_PM     = 1050,
    parameter int OVP_HYS_PM = 15
) (
    input  logic [W-1:0] ref_val,
    output logic [W:0]   lvl_low,
    output logic [W:0]   lvl_high,
    output logic [W:0]   lvl_trip,
    output logic [W:0]   lvl_rel
);
    import lvs_pkg::*;

    localparam int PW = W + 12;
    localparam int NLVL = 4;
    localparam int PM_TAB [NLVL] = '{LOW_PM, HIGH_PM, OVP_PM, OVP_PM - OVP_HYS_PM};

    logic [NLVL-1:0][W:0] lvl;

    // each level is a constant per-mille fraction of the reference
    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        logic [PW-1:0] prod;
        logic [PW-1:0] quot;
        assign prod   = PW'(ref_val) * PW'(PM_TAB[g]);
        assign quot   = prod / PW'(PM_SCALE);
        assign lvl[g] = quot[W:0];
    end

    assign lvl_low  = lvl[0];
    assign lvl_high = lvl[1];
    assign lvl_trip = lvl[2];
    assign lvl_rel  = lvl[3];

    always_comb begin
        assert (lvl_rel <= lvl_trip) else $error("a_r5_release_below_trip");
    end
endmodule

// File: rtl/lvs_ovp.sv
module lvs_ovp #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_vld,
    input  logic [W-1:0] smp_val,
    input  logic [W:0]   lvl_trip,
    input  logic [W:0]   lvl_rel,
    output logic         ovp_inhibit
);
    logic         ovp_q;
    logic [W:0]   smp_x;

    assign smp_x = {1'b0, smp_val};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovp_q <= 1'b0;
        end else if (smp_vld) begin
            if (smp_x > lvl_trip) begin
                ovp_q <= 1'b1;
            end else if (smp_x < lvl_rel) begin
                ovp_q <= 1'b0;
            end
        end
    end

    assign ovp_inhibit = ovp_q;

    a_r4_trip_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && (smp_x > lvl_trip)) |=> ovp_q);
    a_r6_ovp_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(ovp_q));
endmodule

// File: rtl/lvs_ctrl.sv
module lvs_ctrl #(
    parameter int W        = 12,
    parameter int TRIP_MS  = 112,
    parameter int LOCK_MS  = 2500,
    parameter int CLEAR_MS = 112
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_vld,
    input  logic [W-1:0] smp_val,
    input  logic [W:0]   lvl_low,
    input  logic [W:0]   lvl_high,
    input  logic         ms_tick,
    output logic         startup_mode,
    output logic         olp_inhibit
);
    import lvs_pkg::*;

    localparam int OW = $clog2(TRIP_MS + 1);
    localparam int LW = $clog2(LOCK_MS + 1);
    localparam int RW = $clog2(CLEAR_MS + 1);

    lvs_state_e    state_q, state_d;
    logic [OW-1:0] ovl_q;
    logic [LW-1:0] lock_q;
    logic [RW-1:0] run_q;
    logic          above_hi, below_lo, trip, lock_done;

    assign above_hi  = {1'b0, smp_val} >= lvl_high;
    assign below_lo  = {1'b0, smp_val} <  lvl_low;
    assign trip      = ms_tick && (ovl_q >= OW'(TRIP_MS));
    assign lock_done = ms_tick && (lock_q == LW'(LOCK_MS - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: if (smp_vld && above_hi) state_d = ST_RUN;
            ST_RUN:  if (smp_vld && below_lo) state_d = ST_SAG;
            ST_SAG: begin
                if (trip)                     state_d = ST_LOCK;
                else if (smp_vld && above_hi) state_d = ST_RUN;
            end
            ST_LOCK: if (lock_done)           state_d = ST_BOOT;
            default:                          state_d = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // overload accumulator, normal-mode run length, lockout length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovl_q  <= '0;
            lock_q <= '0;
            run_q  <= '0;
        end else begin
            unique case (state_q)
                ST_SAG:  if (ms_tick && !trip) ovl_q <= ovl_q + 1'b1;
                ST_RUN:  if (run_q >= RW'(CLEAR_MS)) ovl_q <= '0;
                ST_LOCK: ovl_q <= '0;
                default: ovl_q <= ovl_q;
            endcase
            if (state_q != ST_RUN)                           run_q <= '0;
            else if (ms_tick && (run_q < RW'(CLEAR_MS)))     run_q <= run_q + 1'b1;
            if (state_q != ST_LOCK)                          lock_q <= '0;
            else if (ms_tick)                                lock_q <= lock_q + 1'b1;
        end
    end

    always_comb begin
        startup_mode = 1'b1;
        olp_inhibit  = 1'b0;
        unique case (state_q)
            ST_RUN:  startup_mode = 1'b0;
            ST_LOCK: olp_inhibit  = 1'b1;
            default: ;
        endcase
    end

    a_r7_ovl_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_q <= OW'(TRIP_MS));
    a_r7_boot_no_accum: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT) |=> $stable(ovl_q));
    a_r9_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && !ms_tick) |=> (state_q == ST_LOCK));
    a_r6_no_vld_no_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && !smp_vld) |=> (state_q != ST_RUN));
    a_r9_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && lock_done) |=> (ovl_q == '0));
endmodule

// File: rtl/link_supervisor.sv
module link_supervisor #(
    parameter int W          = 12,
    parameter int LOW_PM     = 900,
    parameter int HIGH_PM    = 1000,
    parameter int OVP_PM     = 1050,
    parameter int OVP_HYS_PM = 15,
    parameter int TRIP_MS    = 112,
    parameter int LOCK_MS    = 2500,
    parameter int CLEAR_MS   = 112
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_vld,
    input  logic [W-1:0] smp_val,
    input  logic [W-1:0] ref_val,
    input  logic         ms_tick,
    output logic         startup_mode,
    output logic         ovp_inhibit,
    output logic         olp_inhibit,
    output logic         gate_enable
);
    logic [W:0] lvl_low, lvl_high, lvl_trip, lvl_rel;

    lvs_levels #(
        .W(W), .LOW_PM(LOW_PM), .HIGH_PM(HIGH_PM),
        .OVP_PM(OVP_PM), .OVP_HYS_PM(OVP_HYS_PM)
    ) u_levels (
        .ref_val (ref_val),
        .lvl_low (lvl_low),
        .lvl_high(lvl_high),
        .lvl_trip(lvl_trip),
        .lvl_rel (lvl_rel)
    );

    lvs_ovp #(.W(W)) u_ovp (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_vld    (smp_vld),
        .smp_val    (smp_val),
        .lvl_trip   (lvl_trip),
        .lvl_rel    (lvl_rel),
        .ovp_inhibit(ovp_inhibit)
    );

    lvs_ctrl #(
        .W(W), .TRIP_MS(TRIP_MS), .LOCK_MS(LOCK_MS), .CLEAR_MS(CLEAR_MS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_vld     (smp_vld),
        .smp_val     (smp_val),
        .lvl_low     (lvl_low),
        .lvl_high    (lvl_high),
        .ms_tick     (ms_tick),
        .startup_mode(startup_mode),
        .olp_inhibit (olp_inhibit)
    );

    assign gate_enable = !(ovp_inhibit || olp_inhibit);

    a_r9_lock_in_startup: assert property (@(posedge clk) disable iff (!rst_n)
        olp_inhibit |-> startup_mode);
    a_r10_ovp_blocks_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_inhibit |-> !gate_enable);
endmodule

// File: tb/link_supervisor_bench.sv
module link_supervisor_bench;
    localparam int W = 12;
    localparam int TRIP = 5;
    localparam int LOCKT = 8;
    localparam int CLR = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         smp_vld = 1'b0;
    logic [W-1:0] smp_val = '0;
    logic [W-1:0] ref_val = W'(1000);
    logic         ms_tick = 1'b0;
    logic         startup_mode, ovp_inhibit, olp_inhibit, gate_enable;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    link_supervisor #(
        .W(W), .TRIP_MS(TRIP), .LOCK_MS(LOCKT), .CLEAR_MS(CLR)
    ) u_link_supervisor (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_val(smp_val),
        .ref_val(ref_val), .ms_tick(ms_tick), .startup_mode(startup_mode),
        .ovp_inhibit(ovp_inhibit), .olp_inhibit(olp_inhibit),
        .gate_enable(gate_enable)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int v, input logic vld, input logic tk);
        smp_val = W'(v);
        smp_vld = vld;
        ms_tick = tk;
        @(posedge clk);
        @(negedge clk);
        smp_vld = 1'b0;
        ms_tick = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(0, 1'b0, 1'b0);
        rst_n = 1'b1;
        step(0, 1'b0, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(0, 1'b0, 1'b1);
    endtask

    initial begin
        int refs [3] = '{1000, 400, 3000};
        @(negedge clk);
        do_reset();
        chk("R1 startup", int'(startup_mode), 1);
        chk("R1 ovp", int'(ovp_inhibit), 0);
        chk("R1 olp", int'(olp_inhibit), 0);
        chk("R1 gate", int'(gate_enable), 1);

        for (int k = 0; k < 3; k++) begin
            int r, lo, hi, tr, rl;
            r  = refs[k];
            ref_val = W'(r);
            lo = r * 900 / 1000;
            hi = r;
            tr = r * 1050 / 1000;
            rl = r * 1035 / 1000;
            // sweep from fresh state: mode and trip per single sample
            for (int v = 0; v <= r * 11 / 10; v++) begin
                do_reset();
                step(v, 1'b1, 1'b0);
                chk("R2 sweep mode", int'(startup_mode), (v < hi) ? 1 : 0);
                chk("R4 sweep trip", int'(ovp_inhibit), (v > tr) ? 1 : 0);
                chk("R10 sweep gate", int'(gate_enable), (v > tr) ? 0 : 1);
            end
            do_reset();
            step(hi - 1, 1'b1, 1'b0); chk("R2 below high", int'(startup_mode), 1);
            step(hi, 1'b1, 1'b0);     chk("R2 at high", int'(startup_mode), 0);
            step(lo, 1'b1, 1'b0);     chk("R3 at low", int'(startup_mode), 0);
            step(lo - 1, 1'b1, 1'b0); chk("R3 below low", int'(startup_mode), 1);
            step(hi - 1, 1'b1, 1'b0); chk("R2 sag hold", int'(startup_mode), 1);
            step(hi, 1'b1, 1'b0);     chk("R2 sag exit", int'(startup_mode), 0);
            step(tr, 1'b1, 1'b0);     chk("R4 at trip", int'(ovp_inhibit), 0);
            step(tr + 1, 1'b1, 1'b0); chk("R4 over trip", int'(ovp_inhibit), 1);
            step(rl, 1'b1, 1'b0);     chk("R5 at release", int'(ovp_inhibit), 1);
            step(rl - 1, 1'b1, 1'b0); chk("R5 below release", int'(ovp_inhibit), 0);
            step(tr + 1, 1'b1, 1'b0); chk("R5 retrip", int'(ovp_inhibit), 1);
            step(0, 1'b0, 1'b0);      chk("R6 no vld hold ovp", int'(ovp_inhibit), 1);
            step(rl - 1, 1'b1, 1'b0); chk("R5 clear again", int'(ovp_inhibit), 0);
            step(4000, 1'b0, 1'b0);   chk("R6 ignored ovp", int'(ovp_inhibit), 0);
            step(0, 1'b0, 1'b0);      chk("R6 ignored mode", int'(startup_mode), 0);
        end

        ref_val = W'(1000);
        // R7: boot ticks do not accumulate
        do_reset();
        ticks(10);
        chk("R7 boot no lock", int'(olp_inhibit), 0);
        step(1000, 1'b1, 1'b0);
        step(800, 1'b1, 1'b0);
        for (int i = 0; i < TRIP; i++) begin
            step(0, 1'b0, 1'b1);
            chk("R7 accumulating", int'(olp_inhibit), 0);
        end
        step(0, 1'b0, 1'b1);
        chk("R7 trip tick", int'(olp_inhibit), 1);

        // R7: repeated events accumulate across normal intervals
        do_reset();
        step(1000, 1'b1, 1'b0);
        step(800, 1'b1, 1'b0);
        ticks(3);
        step(1000, 1'b1, 1'b0);
        ticks(CLR - 2);
        step(800, 1'b1, 1'b0);
        ticks(TRIP - 3);
        chk("R7 repeat not yet", int'(olp_inhibit), 0);
        step(0, 1'b0, 1'b1);
        chk("R7 repeat lock", int'(olp_inhibit), 1);
        chk("R9 lock startup", int'(startup_mode), 1);
        chk("R10 lock gate", int'(gate_enable), 0);
        step(1000, 1'b1, 1'b0);
        chk("R9 sample ignored", int'(startup_mode), 1);
        step(1100, 1'b1, 1'b0);
        chk("R10 ovp in lock", int'(ovp_inhibit), 1);
        step(0, 1'b1, 1'b0);
        chk("R10 ovp release in lock", int'(ovp_inhibit), 0);
        ticks(LOCKT - 1);
        chk("R9 still locked", int'(olp_inhibit), 1);
        step(0, 1'b0, 1'b1);
        chk("R9 released", int'(olp_inhibit), 0);
        chk("R9 back in startup", int'(startup_mode), 1);
        chk("R9 gate back", int'(gate_enable), 1);

        // R9 restart cleared and R8 clear after normal run
        step(1000, 1'b1, 1'b0);
        chk("R2 after restart", int'(startup_mode), 0);
        step(800, 1'b1, 1'b0);
        ticks(3);
        step(1000, 1'b1, 1'b0);
        ticks(CLR);
        step(800, 1'b1, 1'b0);
        for (int i = 0; i < TRIP; i++) begin
            step(0, 1'b0, 1'b1);
            chk("R8 cleared", int'(olp_inhibit), 0);
        end
        step(0, 1'b0, 1'b1);
        chk("R8 lock after clear", int'(olp_inhibit), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule